// File: doc/BRIEF.md
# Single-Input-Change Test Pattern Generator

This block produces stimulus vectors for built-in self-test in which two successive vectors differ in exactly one bit position, which keeps switching activity in the logic under test low. A binary counter walks through its range. Its value is Gray-coded and XORed with a seed word, and the result is registered as the output vector.

The seed comes from a linear feedback shift register. The register does not run every cycle: it advances only when the low `RUN_LOG` bits of the counter wrap to zero. Each run of `2**RUN_LOG` vectors therefore walks a one-bit-change path from a different pseudorandom starting point. Software or a test controller can load a new seed, which restarts the counter and produces a different family of runs. The seed step uses a plain clock enable, so there is no gated clock.

Top module: `sic_pattern_gen`

## Requirements
- R1: After reset `vec_valid` is 0, the counter is 0 and the seed is `SEED_INIT` (default 8'h5A). The first vector presented after enabling therefore equals 8'h5A.
- R2: Each cycle with `run_en` high and `seed_load` low advances the counter by one, modulo `2**VEC_W`.
- R3: A vector produced at counter value c equals seed XOR (c XOR (c >> 1)). Bit i is c[i] XOR c[i+1] XOR seed[i], and the top bit is c[VEC_W-1] XOR seed[VEC_W-1].
- R4: The seed steps only on the enabled edge at which the next counter value has its low `RUN_LOG` bits all zero. The new seed applies from the first vector of the new run. At default parameters this is once per 256 vectors.
- R5: A seed step shifts the seed left by one, and bit 0 takes seed[7] XOR seed[5] XOR seed[4] XOR seed[3] (polynomial x^8+x^6+x^5+x^4+1). The seed is never zero, and it returns to its start value after 255 steps.
- R6: Within a run, two consecutive valid vectors differ in exactly one bit.
- R7: A cycle with `seed_load` high writes `seed_value` into the seed and clears the counter. The next valid vector equals the loaded seed.
- R8: Loading the value 0 stores 8'h01 instead.
- R9: While `run_en` is low, the counter, the seed and `vec_out` hold their values, and `vec_valid` is 0 from the next cycle on.
- R10: `vec_valid` is high in the cycle after each edge that sees `run_en` high and `seed_load` low, and low otherwise.
- R11: `seed_load` has priority over `run_en`: in a load cycle no vector is produced and the counter does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Advance the generator by one vector per cycle |
| seed_load | input | 1 | Write `seed_value` into the seed and clear the counter |
| seed_value | input | VEC_W | Seed to load (0 is replaced by 1) |
| vec_out | output | VEC_W | Registered test vector |
| vec_valid | output | 1 | `vec_out` was updated on the last edge |

## Verification
A wrong counter or Gray bit shows up on `vec_out` in the very next valid cycle, either as a vector that differs from the reference or as a step that flips zero or two bits. A wrong seed step, or a step on the wrong edge, stays hidden until the next run boundary. At default parameters it can take up to 256 cycles to appear, and it then shows as a run whose first vector is not the expected seed. A feedback tap error can keep every individual run well-formed. It is exposed only by walking all 255 seed steps and checking that the seeds never repeat early and close the cycle.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned VEC_W_DEF   = 8;
  localparam int unsigned RUN_LOG_DEF = 8;
  // feedback mask: bits 7,5,4,3 -> x^8+x^6+x^5+x^4+1
  localparam logic [7:0]  TAPS_DEF    = 8'hB8;
  localparam logic [7:0]  SEED_DEF    = 8'h5A;
endpackage

// File: rtl/sic_run_counter.sv
module sic_run_counter #(
  parameter int unsigned W = 8,
  parameter int unsigned M = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [M-1:0] LOW_ONES = {M{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // next low M bits become zero on this enabled edge
  assign wrap_o = en_i && !clr_i && (cnt_q[M-1:0] == LOW_ONES);
  assign cnt_o  = cnt_q;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sic_seed_lfsr.sv
module sic_seed_lfsr #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] INIT = 8'h5A
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic [W-1:0] seed_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] seed_q, seed_d, tapped;
  logic         fb;

  for (genvar i = 0; i < W; i++) begin : g_tap
    assign tapped[i] = TAPS[i] & seed_q[i];
  end
  assign fb = ^tapped;

  always_comb begin
    seed_d = seed_q;
    if (load_i)      seed_d = (load_val_i == '0) ? ONE : load_val_i;
    else if (step_i) seed_d = {seed_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seed_q <= INIT;
    else        seed_q <= seed_d;
  end

  assign seed_o = seed_q;

  // R5
  seed_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_q != '0);
  // R4
  seed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(seed_q));
  // R8
  zero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i == '0) |=> (seed_q == ONE));
endmodule

// File: rtl/sic_gray_xor.sv
module sic_gray_xor #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] bin_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] vec_o
);
  logic [W-1:0] gray;

  for (genvar i = 0; i < W - 1; i++) begin : g_enc
    assign gray[i] = bin_i[i] ^ bin_i[i+1];
  end
  assign gray[W-1] = bin_i[W-1];

  for (genvar i = 0; i < W; i++) begin : g_mix
    assign vec_o[i] = gray[i] ^ seed_i[i];
  end
endmodule

// File: rtl/sic_pattern_gen.sv
module sic_pattern_gen #(
  parameter int unsigned      VEC_W     = sic_pkg::VEC_W_DEF,
  parameter int unsigned      RUN_LOG   = sic_pkg::RUN_LOG_DEF,
  parameter logic [VEC_W-1:0] TAPS      = sic_pkg::TAPS_DEF,
  parameter logic [VEC_W-1:0] SEED_INIT = sic_pkg::SEED_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             seed_load,
  input  logic [VEC_W-1:0] seed_value,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_valid
);
  localparam logic [RUN_LOG-1:0] RUN_ZERO = '0;

  logic [VEC_W-1:0] cnt, seed, vec_d, vec_q;
  logic             wrap, adv, valid_q, valid_d;

  assign adv = run_en && !seed_load;

  sic_run_counter #(.W(VEC_W), .M(RUN_LOG)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(seed_load), .en_i(run_en),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  sic_seed_lfsr #(.W(VEC_W), .TAPS(TAPS), .INIT(SEED_INIT)) u_seed (
    .clk(clk), .rst_n(rst_n), .load_i(seed_load), .load_val_i(seed_value),
    .step_i(wrap), .seed_o(seed)
  );

  sic_gray_xor #(.W(VEC_W)) u_mix (
    .bin_i(cnt), .seed_i(seed), .vec_o(vec_d)
  );

  assign valid_d = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (adv) vec_q <= vec_d;
    end
  end

  assign vec_out   = vec_q;
  assign vec_valid = valid_q;

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> vec_valid);
  // R6
  sic_onebit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && valid_q && cnt[RUN_LOG-1:0] != RUN_ZERO)
      |=> ($countones(vec_q ^ $past(vec_q)) == 1));
  // R9
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(vec_q) && !vec_valid));
endmodule

// File: tb/sim_sic_pattern_gen.sv
module sim_sic_pattern_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       seed_load = 1'b0;
  logic [7:0] seed_value = 8'h00;
  logic [7:0] vec_out;
  logic       vec_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  sic_pattern_gen u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .seed_load(seed_load),
    .seed_value(seed_value), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  // behavioural reference
  int         m_cnt;
  logic [7:0] m_seed, m_vec;
  bit         m_valid;

  function automatic logic [7:0] ref_step(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_seed = 8'h5A; m_valid = 0; m_vec = 8'h00;
    end else if (seed_load) begin
      m_seed = (seed_value == 8'h00) ? 8'h01 : seed_value;
      m_cnt = 0; m_valid = 0;
    end else if (run_en) begin
      m_vec = m_seed ^ 8'(m_cnt ^ (m_cnt >> 1));
      m_valid = 1;
      m_cnt = (m_cnt + 1) % 256;
      if (m_cnt == 0) m_seed = ref_step(m_seed);
    end else begin
      m_valid = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle state for one-bit and seed checks
  logic [7:0] prev_vec;
  bit         prev_valid = 0;
  int         vidx = 0;
  bit         seed_track = 0;
  logic [7:0] first_seed, last_seed;
  bit         seen [256];

  task automatic cyc(input bit en, input bit ld, input logic [7:0] val);
    @(negedge clk);
    // R10 valid flag, R3 vector value against reference
    check(vec_valid == m_valid, "R10 valid", vec_valid, m_valid);
    if (m_valid) begin
      check(vec_out == m_vec, "R3 vector", vec_out, m_vec);
      if (prev_valid && (vidx % 256) != 0)
        check($countones(vec_out ^ prev_vec) == 1, "R6 one-bit step",
              $countones(vec_out ^ prev_vec), 1);
      if (seed_track && (vidx % 256) == 0) begin
        // R4 run start shows the seed; R5 nonzero and period 255
        check(vec_out != 8'h00, "R5 nonzero seed", vec_out, 1);
        if (vidx == 0) begin
          first_seed = vec_out;
          seen[vec_out] = 1;
        end else if (vidx == 255 * 256) begin
          check(vec_out == first_seed, "R5 period 255", vec_out, first_seed);
        end else begin
          check(vec_out == ref_step(last_seed), "R4 seed step", vec_out, ref_step(last_seed));
          check(!seen[vec_out], "R5 no early repeat", vec_out, 0);
          seen[vec_out] = 1;
        end
        last_seed = vec_out;
      end
      prev_vec = vec_out;
      vidx++;
    end
    prev_valid = m_valid;
    run_en = en; seed_load = ld; seed_value = val;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(vec_valid == 1'b0, "R1 valid low in reset", vec_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vec_valid == 1'b0, "R1 valid low after reset", vec_valid, 0);
    seed_track = 1;
    run_en = 1'b1;
    @(negedge clk);
    // R1 first vector is the reset seed
    check(vec_out == 8'h5A && vec_valid, "R1 first vector", vec_out, 8'h5A);
    prev_vec = vec_out; prev_valid = 1; vidx = 1;
    seen[vec_out] = 1; first_seed = vec_out; last_seed = vec_out;
    for (int i = 0; i < 255 * 256 + 2; i++) cyc(1, 0, 8'h00);
    seed_track = 0;
    // R9 pause: outputs hold
    cyc(0, 0, 8'h00);
    begin
      logic [7:0] held;
      held = vec_out;
      for (int i = 0; i < 4; i++) begin
        cyc(0, 0, 8'h00);
        check(vec_out == held, "R9 hold vec", vec_out, held);
        check(vec_valid == 1'b0, "R9 valid low", vec_valid, 0);
      end
    end
    for (int i = 0; i < 20; i++) cyc(1, 0, 8'h00);
    // R11 load with enable high; R7 next vector is loaded seed
    cyc(1, 1, 8'hC3);
    cyc(1, 0, 8'h00);
    check(vec_valid == 1'b0, "R11 no vector in load cycle", vec_valid, 0);
    vidx = 0; prev_valid = 0;
    cyc(1, 0, 8'h00);
    check(vec_out == 8'hC3, "R7 loaded seed", vec_out, 8'hC3);
    for (int i = 0; i < 300; i++) cyc(1, 0, 8'h00);
    // R8 zero load
    cyc(0, 1, 8'h00);
    vidx = 0; prev_valid = 0;
    cyc(1, 0, 8'h00);
    cyc(1, 0, 8'h00);
    check(vec_out == 8'h01, "R8 zero load", vec_out, 8'h01);
    for (int i = 0; i < 10; i++) cyc(1, 0, 8'h00);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule